// File: doc/BRIEF.md
# Two-Stage Serial-Clock Prescaler

This block derives the timing of a two-wire serial bus clock from a much faster system clock. Two cascaded counters divide the input: the first divides by (A+1), where A is a 2-bit value, and the second divides its output by (B+1), where B is a 6-bit value. Each prescaled step is presented as a one-cycle tick. A third counter groups eleven ticks into one half of the bus clock and flips a free-running reference level. A full bus-clock period therefore spans 22 × (A+1) × (B+1) input clocks at an even 50% duty.

The surrounding controller drives the enable and the two divisor fields, and uses the ticks to step its bit-level sequencing. The divisor inputs are sampled freely while the block is disabled. While it runs, they are captured only when a new period begins, so a reprogrammed rate never produces a shortened or stretched phase. When enable is low, every counter is held at zero and the reference level sits high, which is the idle level of the bus.

Top module: `scl_div_top`

## Requirements
- R1: While enabled, with M = (A+1)×(B+1), tick_o is high for exactly one cycle in every M input clocks. With A=0 and B=0 (M=1), tick_o is high on every cycle.
- R2: div_a_i is 2 bits wide and gives factors 1 to 4. div_b_i is 6 bits wide and gives factors 1 to 64. The combined prescale therefore reaches 256 at A=3, B=63.
- R3: scl_ref_o changes only in a cycle in which tick_o is high, and it toggles on every 11th tick. Each high and each low phase lasts 11×M input clocks and contains exactly 11 ticks, so a period lasts 22×M clocks.
- R4: After enable rises, scl_ref_o begins in its high phase. The first tick appears in the M-th cycle after the first enabled clock edge, and the first fall of scl_ref_o follows 11×M cycles after that edge.
- R5: With en_i low at a clock edge, tick_o is low and scl_ref_o is high after that edge, and they stay so while en_i stays low.
- R6: A change of div_a_i or div_b_i while enabled takes effect only when scl_ref_o next rises (the start of a new period). The phases in progress keep the old rate.
- R7: While disabled, the divisor inputs are followed directly, so the first period after enable uses the values present when enable rises.
- R8: During and directly after reset, tick_o is low and scl_ref_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears all counters |
| div_a_i | input | 2 | First-stage divisor A, factor A+1 |
| div_b_i | input | 6 | Second-stage divisor B, factor B+1 |
| tick_o | output | 1 | One-cycle pulse per prescaled step |
| scl_ref_o | output | 1 | Bus-clock reference level, idle high |

## Verification
On every cycle, the assertions check four things: the disabled state of the outputs, that the reference level moves only together with a tick, that the captured divisors are replaced only at a rising reference edge, and that both prescale counters stay within their captured limits. Only the bench's scenarios can show the actual lengths. These are the tick spacing, the 11-tick phase length for divisor pairs up to the 256 extreme, a reprogrammed rate applying one whole period later, and divisor values taken directly at enable.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int DIV_A_W    = 2;
  localparam int DIV_B_W    = 6;
  localparam int HALF_STEPS = 11;
endpackage

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_lim;

  assign at_lim = (cnt_q == limit_i);
  assign wrap_o = adv_i & at_lim & ~clr_i;
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (adv_i)  cnt_d = at_lim ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_div_level.sv
module scl_div_level #(
  parameter int HALF = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic level_o,
  output logic boundary_o
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF - 1);

  logic          half_wrap;
  logic [PW-1:0] half_cnt;
  logic          level_q, level_d;

  scl_div_stage #(.W(PW)) u_half (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .adv_i  (step_i),
    .limit_i(LAST),
    .cnt_o  (half_cnt),
    .wrap_o (half_wrap)
  );

  // a new period starts when the low phase ends
  assign boundary_o = half_wrap & ~level_q;
  assign level_o    = level_q;

  always_comb begin
    level_d = level_q;
    if (clr_i)          level_d = 1'b1;
    else if (half_wrap) level_d = ~level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level_d;
  end
endmodule

// File: rtl/scl_div_top.sv
module scl_div_top
  import scl_div_pkg::*;
#(
  parameter int A_W  = DIV_A_W,
  parameter int B_W  = DIV_B_W,
  parameter int HALF = HALF_STEPS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic [B_W-1:0] div_b_i,
  output logic           tick_o,
  output logic           scl_ref_o
);
  logic           clr;
  logic           lat_en;
  logic           boundary;
  logic           wrap_a;
  logic           step;
  logic [A_W-1:0] cnt_a;
  logic [B_W-1:0] cnt_b;
  logic [A_W-1:0] div_a_q, div_a_d;
  logic [B_W-1:0] div_b_q, div_b_d;
  logic           tick_q, tick_d;

  assign clr    = ~en_i;
  assign lat_en = clr | boundary;

  // divisor capture: open while idle, otherwise only at a period start
  always_comb begin
    div_a_d = div_a_q;
    div_b_d = div_b_q;
    if (lat_en) begin
      div_a_d = div_a_i;
      div_b_d = div_b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_a_q <= '0;
      div_b_q <= '0;
    end else begin
      div_a_q <= div_a_d;
      div_b_q <= div_b_d;
    end
  end

  scl_div_stage #(.W(A_W)) u_stage_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .adv_i  (en_i),
    .limit_i(div_a_q),
    .cnt_o  (cnt_a),
    .wrap_o (wrap_a)
  );

  scl_div_stage #(.W(B_W)) u_stage_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .adv_i  (wrap_a),
    .limit_i(div_b_q),
    .cnt_o  (cnt_b),
    .wrap_o (step)
  );

  scl_div_level #(.HALF(HALF)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .step_i    (step),
    .level_o   (scl_ref_o),
    .boundary_o(boundary)
  );

  assign tick_d = step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/scl_div_chk.sv
module scl_div_chk #(
  parameter int A_W = 2,
  parameter int B_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_i,
  input logic           tick_o,
  input logic           scl_ref_o,
  input logic [A_W-1:0] lat_a,
  input logic [B_W-1:0] lat_b,
  input logic [A_W-1:0] cnt_a,
  input logic [B_W-1:0] cnt_b
);
  // R5: disabled state at the outputs
  a_r5_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!tick_o && scl_ref_o));

  // R3: the reference level only moves together with a tick while running
  a_r3_level_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && !$stable(scl_ref_o)) |-> tick_o);

  // R6: captured divisors change only at a rising reference edge while running
  a_r6_capture_at_period: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && !$stable({lat_a, lat_b})) |-> $rose(scl_ref_o));

  // R1: prescale counters never pass their captured limits
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a <= lat_a) && (cnt_b <= lat_b));
endmodule

bind scl_div_top scl_div_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .tick_o   (tick_o),
  .scl_ref_o(scl_ref_o),
  .lat_a    (div_a_q),
  .lat_b    (div_b_q),
  .cnt_a    (cnt_a),
  .cnt_b    (cnt_b)
);

// File: tb/scl_div_top_tb.sv
module scl_div_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] div_a = '0;
  logic [5:0] div_b = '0;
  logic       tick;
  logic       scl;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  scl_div_top u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .div_a_i  (div_a),
    .div_b_i  (div_b),
    .tick_o   (tick),
    .scl_ref_o(scl)
  );

  // {A[16:15], B[14:9], expected step length M[8:0]}
  localparam logic [16:0] VEC [5] = '{
    {2'd0, 6'd0,  9'd1},
    {2'd1, 6'd2,  9'd6},
    {2'd2, 6'd9,  9'd30},
    {2'd0, 6'd5,  9'd6},
    {2'd3, 6'd63, 9'd256}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles until scl changes, and ticks seen meanwhile (toggle tick included)
  task automatic phase(output int len, output int nt);
    logic prev;
    prev = scl;
    len = 0;
    nt = 0;
    do begin
      @(negedge clk);
      len++;
      if (tick) nt++;
    end while (scl == prev && len < 20000);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!tick && g < 1000);
  endtask

  task automatic start(input logic [1:0] a, input logic [5:0] b);
    @(negedge clk);
    en = 1'b0;
    div_a = a;
    div_b = b;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int len, nt, g, m;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R8 tick in reset", tick, 0);
    chk(scl == 1'b1, "R8 scl in reset", scl, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tick == 1'b0 && scl == 1'b1, "R8 after reset", {tick, scl}, 1);

    // table walk: R1, R2, R3, R4
    for (int i = 0; i < 5; i++) begin
      m = int'(VEC[i][8:0]);
      start(VEC[i][16:15], VEC[i][14:9]);
      gap(g);
      chk(g == m, "R4 first tick", g, m);
      phase(len, nt);
      chk(len == 11 * m - g, "R4 first fall", len + g, 11 * m);
      phase(len, nt);
      chk(len == 11 * m, "R3 low phase length", len, 11 * m);
      chk(nt == 11, "R3 ticks per phase", nt, 11);
      gap(g);
      chk(g == m, (i == 4) ? "R2 max prescale" : "R1 tick spacing", g, m);
    end

    // R6: change while running applies at next rising edge only
    start(2'd0, 6'd1);
    repeat (5) @(negedge clk);
    div_a = 2'd1;
    div_b = 6'd2;
    phase(len, nt);
    chk(len == 22 - 5, "R6 high phase keeps old rate", len + 5, 22);
    phase(len, nt);
    chk(len == 22, "R6 low phase keeps old rate", len, 22);
    phase(len, nt);
    chk(len == 66, "R6 new rate after rise", len, 66);

    // R5: disable mid-run
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(tick == 1'b0 && scl == 1'b1, "R5 idle after disable", {tick, scl}, 1);
    g = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick || !scl) g++;
    end
    chk(g == 0, "R5 idle held", g, 0);

    // R7: inputs while disabled used directly at enable
    div_a = 2'd3;
    div_b = 6'd0;
    @(negedge clk);
    en = 1'b1;
    phase(len, nt);
    chk(len == 44, "R7 first phase uses idle inputs", len, 44);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule